// File: doc/BRIEF.md
# Rectangle Tiled Transfer Sequencer

This block turns one rectangle request into an ordered stream of transfer commands for a surface stored in micro-tiles. A request gives the rectangle origin, its width and height, a bytes-per-pixel code, a direction flag (load or store) and the byte stride of the linear buffer on the other side. The sequencer issues one command per accepted handshake. Each command says whether it moves a whole micro-tile or a single pixel, and gives the surface coordinate it starts at and the matching byte offset into the linear buffer. The tiled byte address and the data movement belong to a downstream address generator and datapath.

The rectangle is split into an interior aligned to micro-tile boundaries, which moves one whole micro-tile per command, and up to four edge strips that move one pixel per command. When there is no aligned interior, the rectangle is walked pixel by pixel instead. A single-cycle done pulse marks the end of each request.

Top module: `tiled_xfer_seq`

## Requirements
- R1: The micro-tile size in pixels (width x height) depends on `bpp_code`: 0 means 1 byte/pixel and 8x8, 1 means 2 bytes and 8x4, 2 means 4 bytes and 4x4, 3 means 8 bytes and 4x2, and codes 4 to 7 mean 16 bytes and 2x2.
- R2: The interior spans columns from x rounded up to a tile multiple to x+width rounded down to one, and likewise for rows. When it is not empty, it is issued first, walking rows of tiles from top to bottom and left to right within a row. Each command has `cmd_whole`=1 and the coordinate of the tile's top-left pixel.
- R3: If the interior is empty in either axis, every pixel of the rectangle is issued once with `cmd_whole`=0. Rows run from top to bottom, and columns from left to right within a row. No strip walk takes place.
- R4: After the interior come per-pixel strips (`cmd_whole`=0), always in this order: top, bottom, left, right. Top covers rows from y to the rounded-up start and bottom covers rows from the rounded-down end to y+height, both over the full width. Left and right cover only the interior rows, in the columns left of the interior and right of it.
- R5: A strip of zero width or zero height emits no commands.
- R6: `cmd_lin_off` equals (cmd_ty - y) * stride + (cmd_tx - x) * bytes_per_pixel.
- R7: While `cmd_valid` is high and `cmd_ready` is low, every command output keeps its value in the next cycle.
- R8: A request is taken only when `start_valid` and `start_ready` are both high. `start_ready` is low from acceptance until the done pulse, and request inputs seen in that time have no effect.
- R9: `done` is high for exactly one cycle, in the cycle after the last command is accepted. A rectangle with zero width or height gives a done pulse and no commands.
- R10: After reset, `cmd_valid` and `done` are low and `start_ready` is high.
- R11: `cmd_load` repeats the direction flag of the request being served.
- R12: Every command coordinate lies inside the requested rectangle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Request present |
| start_ready | output | 1 | Sequencer idle, request can be taken |
| rect_x | input | CW | Rectangle left column |
| rect_y | input | CW | Rectangle top row |
| rect_w | input | CW | Rectangle width in pixels |
| rect_h | input | CW | Rectangle height in pixels |
| bpp_code | input | 3 | Bytes-per-pixel code (R1) |
| dir_load | input | 1 | 1 = load from surface, 0 = store to it |
| lin_stride | input | SW | Linear buffer row stride in bytes |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_whole | output | 1 | 1 = whole micro-tile, 0 = single pixel |
| cmd_load | output | 1 | Direction of the command |
| cmd_tx | output | CW+1 | Surface column of the command |
| cmd_ty | output | CW+1 | Surface row of the command |
| cmd_lin_off | output | CW+SW+2 | Linear buffer byte offset |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The rectangles are chosen to give different shapes of split. One has unaligned edges on all four sides around a single interior tile, so every strip and the strip order appear. One is fully aligned, so all four strips are empty and must be skipped. One is smaller than a tile, which forces the pixel walk. One has zero width and must produce only a done pulse. Other cases cover the 2x2 and 4x2 tile shapes and an out-of-range bpp code, which separates the tile-size mapping of each code. Irregular consumer stalls check that the outputs hold and that each command is accepted exactly once. A request changed while the block is busy checks that it is ignored.

// File: rtl/tiler_pkg.sv
package tiler_pkg;

  // Walk phases, numbered in issue order.
  typedef enum logic [2:0] {
    PH_NONE  = 3'd0,
    PH_INNER = 3'd1,
    PH_TOP   = 3'd2,
    PH_BOT   = 3'd3,
    PH_LEFT  = 3'd4,
    PH_RIGHT = 3'd5,
    PH_FLAT  = 3'd6,
    PH_SPARE = 3'd7
  } phase_e;

  localparam int NPH = 8;

  // First phase after cur whose region is available; PH_NONE if none.
  function automatic logic [2:0] first_after(input logic [2:0] cur,
                                             input logic [NPH-1:0] avail);
    logic [2:0] r;
    r = 3'd0;
    for (int i = NPH - 1; i >= 1; i--) begin
      if (i > int'(cur) && avail[i]) r = 3'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/utile_geom.sv
module utile_geom (
  input  logic [2:0] bpp_code,
  output logic [1:0] log_w,
  output logic [1:0] log_h,
  output logic [2:0] log_b
);
  always_comb begin
    case (bpp_code)
      3'd0:    begin log_w = 2'd3; log_h = 2'd3; log_b = 3'd0; end
      3'd1:    begin log_w = 2'd3; log_h = 2'd2; log_b = 3'd1; end
      3'd2:    begin log_w = 2'd2; log_h = 2'd2; log_b = 3'd2; end
      3'd3:    begin log_w = 2'd2; log_h = 2'd1; log_b = 3'd3; end
      default: begin log_w = 2'd1; log_h = 2'd1; log_b = 3'd4; end
    endcase
  end
endmodule

// File: rtl/rect_splitter.sv
module rect_splitter import tiler_pkg::*; #(
  parameter int XW = 13
) (
  input  logic [XW-1:0]          x1,
  input  logic [XW-1:0]          y1,
  input  logic [XW-1:0]          x2,
  input  logic [XW-1:0]          y2,
  input  logic [1:0]             log_w,
  input  logic [1:0]             log_h,
  output logic                   fallback,
  output logic [NPH-1:0][XW-1:0] xs,
  output logic [NPH-1:0][XW-1:0] xe,
  output logic [NPH-1:0][XW-1:0] ys,
  output logic [NPH-1:0][XW-1:0] ye,
  output logic [NPH-1:0]         avail
);
  logic [XW-1:0] mw, mh, ax1, ax2, ay1, ay2;

  assign mw  = ~({XW{1'b1}} << log_w);
  assign mh  = ~({XW{1'b1}} << log_h);
  assign ax1 = (x1 + mw) & ~mw;
  assign ay1 = (y1 + mh) & ~mh;
  assign ax2 = x2 & ~mw;
  assign ay2 = y2 & ~mh;
  assign fallback = (ax2 <= ax1) || (ay2 <= ay1);

  always_comb begin
    xs = '0; xe = '0; ys = '0; ye = '0;
    xs[PH_INNER] = ax1; xe[PH_INNER] = ax2; ys[PH_INNER] = ay1; ye[PH_INNER] = ay2;
    xs[PH_TOP]   = x1;  xe[PH_TOP]   = x2;  ys[PH_TOP]   = y1;  ye[PH_TOP]   = ay1;
    xs[PH_BOT]   = x1;  xe[PH_BOT]   = x2;  ys[PH_BOT]   = ay2; ye[PH_BOT]   = y2;
    xs[PH_LEFT]  = x1;  xe[PH_LEFT]  = ax1; ys[PH_LEFT]  = ay1; ye[PH_LEFT]  = ay2;
    xs[PH_RIGHT] = ax2; xe[PH_RIGHT] = x2;  ys[PH_RIGHT] = ay1; ye[PH_RIGHT] = ay2;
    xs[PH_FLAT]  = x1;  xe[PH_FLAT]  = x2;  ys[PH_FLAT]  = y1;  ye[PH_FLAT]  = y2;
  end

  for (genvar p = 0; p < NPH; p++) begin : g_avail
    if (p == int'(PH_FLAT)) begin : g_flat
      assign avail[p] = fallback && (xe[p] > xs[p]) && (ye[p] > ys[p]);
    end else if (p >= int'(PH_INNER) && p <= int'(PH_RIGHT)) begin : g_split
      assign avail[p] = !fallback && (xe[p] > xs[p]) && (ye[p] > ys[p]);
    end else begin : g_unused
      assign avail[p] = 1'b0;
    end
  end
endmodule

// File: rtl/lin_offset.sv
module lin_offset #(
  parameter int XW = 13,
  parameter int SW = 16,
  parameter int OW = XW + SW + 1
) (
  input  logic [XW-1:0] tx,
  input  logic [XW-1:0] ty,
  input  logic [XW-1:0] x0,
  input  logic [XW-1:0] y0,
  input  logic [SW-1:0] stride,
  input  logic [2:0]    log_b,
  output logic [OW-1:0] off
);
  logic [XW-1:0] dx, dy;
  assign dx  = tx - x0;
  assign dy  = ty - y0;
  assign off = (OW'(dy) * OW'(stride)) + (OW'(dx) << log_b);
endmodule

// File: rtl/tiled_xfer_seq.sv
module tiled_xfer_seq import tiler_pkg::*; #(
  parameter int CW = 12,
  parameter int SW = 16,
  localparam int XW = CW + 1,
  localparam int OW = XW + SW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic [CW-1:0] rect_x,
  input  logic [CW-1:0] rect_y,
  input  logic [CW-1:0] rect_w,
  input  logic [CW-1:0] rect_h,
  input  logic [2:0]    bpp_code,
  input  logic          dir_load,
  input  logic [SW-1:0] lin_stride,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_whole,
  output logic          cmd_load,
  output logic [XW-1:0] cmd_tx,
  output logic [XW-1:0] cmd_ty,
  output logic [OW-1:0] cmd_lin_off,
  output logic          done
);
  // Latched request
  logic          busy;
  logic [XW-1:0] r_x, r_y, r_x2, r_y2;
  logic [2:0]    r_code;
  logic          r_load;
  logic [SW-1:0] r_stride;
  logic [2:0]    phase;

  logic [1:0] log_w, log_h;
  logic [2:0] log_b;
  logic       fallback;
  logic [NPH-1:0][XW-1:0] xs, xe, ys, ye;
  logic [NPH-1:0] avail;

  utile_geom u_geom (
    .bpp_code (r_code),
    .log_w    (log_w),
    .log_h    (log_h),
    .log_b    (log_b)
  );

  rect_splitter #(.XW(XW)) u_split (
    .x1       (r_x),
    .y1       (r_y),
    .x2       (r_x2),
    .y2       (r_y2),
    .log_w    (log_w),
    .log_h    (log_h),
    .fallback (fallback),
    .xs       (xs),
    .xe       (xe),
    .ys       (ys),
    .ye       (ye),
    .avail    (avail)
  );

  // Next-command computation
  logic [XW:0]   adv_x, adv_y;
  logic          stay;
  logic [2:0]    base_ph, np, n_phase;
  logic [XW-1:0] n_tx, n_ty;
  logic [OW-1:0] n_off;
  logic          have_next;

  always_comb begin
    if (phase == PH_INNER) begin
      adv_x = {1'b0, cmd_tx} + ((XW+1)'(1) << log_w);
      adv_y = {1'b0, cmd_ty} + ((XW+1)'(1) << log_h);
    end else begin
      adv_x = {1'b0, cmd_tx} + (XW+1)'(1);
      adv_y = {1'b0, cmd_ty} + (XW+1)'(1);
    end
    base_ph = cmd_valid ? phase : 3'(PH_NONE);
    np      = first_after(base_ph, avail);
    stay    = 1'b0;
    n_tx    = xs[np];
    n_ty    = ys[np];
    n_phase = np;
    if (cmd_valid) begin
      if (adv_x < {1'b0, xe[phase]}) begin
        stay = 1'b1; n_tx = adv_x[XW-1:0]; n_ty = cmd_ty;  n_phase = phase;
      end else if (adv_y < {1'b0, ye[phase]}) begin
        stay = 1'b1; n_tx = xs[phase];     n_ty = adv_y[XW-1:0]; n_phase = phase;
      end
    end
    have_next = stay || (np != 3'(PH_NONE));
  end

  lin_offset #(.XW(XW), .SW(SW), .OW(OW)) u_off (
    .tx     (n_tx),
    .ty     (n_ty),
    .x0     (r_x),
    .y0     (r_y),
    .stride (r_stride),
    .log_b  (log_b),
    .off    (n_off)
  );

  assign start_ready = !busy;
  assign cmd_load    = r_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      cmd_valid   <= 1'b0;
      done        <= 1'b0;
      phase       <= 3'(PH_NONE);
      r_x         <= '0;
      r_y         <= '0;
      r_x2        <= '0;
      r_y2        <= '0;
      r_code      <= '0;
      r_load      <= 1'b0;
      r_stride    <= '0;
      cmd_whole   <= 1'b0;
      cmd_tx      <= '0;
      cmd_ty      <= '0;
      cmd_lin_off <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start_valid) begin
          busy     <= 1'b1;
          r_x      <= XW'(rect_x);
          r_y      <= XW'(rect_y);
          r_x2     <= XW'(rect_x) + XW'(rect_w);
          r_y2     <= XW'(rect_y) + XW'(rect_h);
          r_code   <= bpp_code;
          r_load   <= dir_load;
          r_stride <= lin_stride;
        end
      end else if (!cmd_valid || cmd_ready) begin
        if (have_next) begin
          cmd_valid   <= 1'b1;
          phase       <= n_phase;
          cmd_whole   <= (n_phase == 3'(PH_INNER));
          cmd_tx      <= n_tx;
          cmd_ty      <= n_ty;
          cmd_lin_off <= n_off;
        end else begin
          cmd_valid <= 1'b0;
          busy      <= 1'b0;
          done      <= 1'b1;
          phase     <= 3'(PH_NONE);
        end
      end
    end
  end
endmodule

// File: rtl/tiled_xfer_seq_checker.sv
module tiled_xfer_seq_checker #(
  parameter int CW = 12,
  parameter int SW = 16,
  localparam int XW = CW + 1,
  localparam int OW = XW + SW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          start_valid,
  input logic          start_ready,
  input logic [CW-1:0] rect_x,
  input logic [CW-1:0] rect_y,
  input logic [CW-1:0] rect_w,
  input logic [CW-1:0] rect_h,
  input logic          dir_load,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_whole,
  input logic          cmd_load,
  input logic [XW-1:0] cmd_tx,
  input logic [XW-1:0] cmd_ty,
  input logic [OW-1:0] cmd_lin_off,
  input logic          done
);
  logic [XW:0] lx, ly, lx2, ly2;
  logic        lload;

  always_ff @(posedge clk) begin
    if (rst) begin
      lx <= '0; ly <= '0; lx2 <= '0; ly2 <= '0; lload <= 1'b0;
    end else if (start_valid && start_ready) begin
      lx    <= (XW+1)'(rect_x);
      ly    <= (XW+1)'(rect_y);
      lx2   <= (XW+1)'(rect_x) + (XW+1)'(rect_w);
      ly2   <= (XW+1)'(rect_y) + (XW+1)'(rect_h);
      lload <= dir_load;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_tx) && $stable(cmd_ty)
      && $stable(cmd_lin_off) && $stable(cmd_whole) && $stable(cmd_load));

  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !start_ready);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_valid && start_ready);

  assert_dir_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_load == lload);

  assert_inside_R12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ({1'b0, cmd_tx} >= lx) && ({1'b0, cmd_tx} < lx2)
      && ({1'b0, cmd_ty} >= ly) && ({1'b0, cmd_ty} < ly2));
endmodule

bind tiled_xfer_seq tiled_xfer_seq_checker #(.CW(CW), .SW(SW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .rect_x      (rect_x),
  .rect_y      (rect_y),
  .rect_w      (rect_w),
  .rect_h      (rect_h),
  .dir_load    (dir_load),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_whole   (cmd_whole),
  .cmd_load    (cmd_load),
  .cmd_tx      (cmd_tx),
  .cmd_ty      (cmd_ty),
  .cmd_lin_off (cmd_lin_off),
  .done        (done)
);

// File: tb/tiled_xfer_seq_test.sv
module tiled_xfer_seq_test;
  localparam int CW = 12;
  localparam int SW = 16;
  localparam int XW = CW + 1;
  localparam int OW = XW + SW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [CW-1:0] rect_x = '0, rect_y = '0, rect_w = '0, rect_h = '0;
  logic [2:0]    bpp_code = '0;
  logic          dir_load = 1'b0;
  logic [SW-1:0] lin_stride = '0;
  logic          cmd_valid, cmd_ready = 1'b0, cmd_whole, cmd_load, done;
  logic [XW-1:0] cmd_tx, cmd_ty;
  logic [OW-1:0] cmd_lin_off;

  always #10 clk = ~clk;   // 50 MHz

  tiled_xfer_seq #(.CW(CW), .SW(SW)) uut (
    .clk (clk), .rst (rst),
    .start_valid (start_valid), .start_ready (start_ready),
    .rect_x (rect_x), .rect_y (rect_y), .rect_w (rect_w), .rect_h (rect_h),
    .bpp_code (bpp_code), .dir_load (dir_load), .lin_stride (lin_stride),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_whole (cmd_whole),
    .cmd_load (cmd_load), .cmd_tx (cmd_tx), .cmd_ty (cmd_ty),
    .cmd_lin_off (cmd_lin_off), .done (done)
  );

  int checks = 0, fails = 0, cyc = 0, done_cnt = 0, rmode = 0;
  int ex_x, ex_y, ex_stride, ex_bytes, ex_load;
  int qw[$], qx[$], qy[$], qo[$];
  string qtag[$];
  bit acc_pend = 0, hold_pend = 0;
  int h_tx, h_ty, h_off, h_whole;

  task automatic push_cmd(input int whole, input int tx, input int ty, input string tag);
    qw.push_back(whole); qx.push_back(tx); qy.push_back(ty);
    qo.push_back((ty - ex_y) * ex_stride + (tx - ex_x) * ex_bytes);
    qtag.push_back(tag);
  endtask

  task automatic push_box(input int xa, input int xb, input int ya, input int yb, input string tag);
    for (int yy = ya; yy < yb; yy++)
      for (int xx = xa; xx < xb; xx++) push_cmd(0, xx, yy, tag);
  endtask

  // Reference split of one request.
  task automatic build(input int x, input int y, input int w, input int h, input int code);
    int tw, th, x2, y2, ax1, ax2, ay1, ay2;
    // R1: tile shape and pixel size from the code
    case (code)
      0: begin tw = 8; th = 8; ex_bytes = 1;  end
      1: begin tw = 8; th = 4; ex_bytes = 2;  end
      2: begin tw = 4; th = 4; ex_bytes = 4;  end
      3: begin tw = 4; th = 2; ex_bytes = 8;  end
      default: begin tw = 2; th = 2; ex_bytes = 16; end
    endcase
    x2 = x + w; y2 = y + h;
    ax1 = ((x + tw - 1) / tw) * tw; ay1 = ((y + th - 1) / th) * th;
    ax2 = (x2 / tw) * tw;          ay2 = (y2 / th) * th;
    if (ax2 <= ax1 || ay2 <= ay1) begin
      push_box(x, x2, y, y2, "R3");
    end else begin
      for (int yy = ay1; yy < ay2; yy += th)
        for (int xx = ax1; xx < ax2; xx += tw) push_cmd(1, xx, yy, "R2");
      push_box(x, x2, y, ay1, "R4");     // top
      push_box(x, x2, ay2, y2, "R4");    // bottom
      push_box(x, ax1, ay1, ay2, "R4");  // left
      push_box(ax2, x2, ay1, ay2, "R4"); // right
    end
  endtask

  // Per-clock comparison against the reference queue.
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      acc_pend = 0; hold_pend = 0; cmd_ready = 0;
    end else begin
      bit rdy;
      if (acc_pend && qx.size() > 0) begin
        void'(qw.pop_front()); void'(qx.pop_front()); void'(qy.pop_front());
        void'(qo.pop_front()); void'(qtag.pop_front());
      end
      if (hold_pend) begin
        checks++;
        if (cmd_valid !== 1'b1 || int'(cmd_tx) != h_tx || int'(cmd_ty) != h_ty ||
            int'(cmd_lin_off) != h_off || int'(cmd_whole) != h_whole) begin
          fails++;
          $display("FAIL R7 held command changed: tx=%0d ty=%0d off=%0d expected tx=%0d ty=%0d off=%0d",
                   cmd_tx, cmd_ty, cmd_lin_off, h_tx, h_ty, h_off);
        end
      end
      if (cmd_valid === 1'b1) begin
        checks++;
        if (qx.size() == 0) begin
          fails++;   // R12: no command beyond the expected set
          $display("FAIL R12 unexpected command tx=%0d ty=%0d expected none", cmd_tx, cmd_ty);
        end else begin
          if (int'(cmd_whole) != qw[0] || int'(cmd_tx) != qx[0] || int'(cmd_ty) != qy[0]) begin
            fails++;
            $display("FAIL %s command whole=%0d tx=%0d ty=%0d expected whole=%0d tx=%0d ty=%0d",
                     qtag[0], cmd_whole, cmd_tx, cmd_ty, qw[0], qx[0], qy[0]);
          end
          checks++;
          if (int'(cmd_lin_off) != qo[0]) begin
            fails++;
            $display("FAIL R6 offset %0d expected %0d", cmd_lin_off, qo[0]);
          end
          checks++;
          if (int'(cmd_load) != ex_load) begin
            fails++;
            $display("FAIL R11 direction %0d expected %0d", cmd_load, ex_load);
          end
        end
      end
      if (done === 1'b1) begin
        done_cnt++;
        checks++;
        if (qx.size() != 0 || cmd_valid !== 1'b0) begin
          fails++;
          $display("FAIL R9 done with %0d commands left, valid=%0d expected 0 and 0", qx.size(), cmd_valid);
        end
      end
      rdy = (rmode == 0) ? 1'b1 : ((cyc % rmode) != 1);
      cmd_ready = rdy;
      acc_pend  = (cmd_valid === 1'b1) && rdy;
      hold_pend = (cmd_valid === 1'b1) && !rdy;
      h_tx = int'(cmd_tx); h_ty = int'(cmd_ty); h_off = int'(cmd_lin_off); h_whole = int'(cmd_whole);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired: cycles=%0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic run_rect(input int x, input int y, input int w, input int h, input int code,
                          input int ld, input int stride, input bit poke);
    int d0;
    ex_x = x; ex_y = y; ex_stride = stride; ex_load = ld;
    build(x, y, w, h, code);
    d0 = done_cnt;
    @(negedge clk);
    rect_x = CW'(x); rect_y = CW'(y); rect_w = CW'(w); rect_h = CW'(h);
    bpp_code = 3'(code); dir_load = ld[0]; lin_stride = SW'(stride);
    start_valid = 1'b1;
    @(negedge clk);
    if (poke) begin
      // R8: a different request while busy must not disturb the stream
      rect_x = 12'd100; rect_y = 12'd50; rect_w = 12'd3; rect_h = 12'd3;
      bpp_code = 3'd0; dir_load = ~dir_load; lin_stride = 16'd7;
      checks++;
      if (start_ready !== 1'b0) begin
        fails++;
        $display("FAIL R8 start_ready=%0d while busy expected 0", start_ready);
      end
      repeat (6) @(negedge clk);
    end
    start_valid = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    checks++;
    if (qx.size() != 0) begin
      fails++;
      $display("FAIL R5 run ended with %0d commands outstanding expected 0", qx.size());
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;   // R10 reset state
    if (cmd_valid !== 1'b0 || done !== 1'b0 || start_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 valid=%0d done=%0d ready=%0d expected 0 0 1", cmd_valid, done, start_ready);
    end
    // R2 R4: unaligned on all sides, 4x4 tiles, busy-time poke (R8), steady ready
    rmode = 0; run_rect(1, 2, 10, 9, 2, 1, 64, 1);
    // R5: fully aligned 8x8 tiles, every strip empty, stalls
    rmode = 3; run_rect(0, 0, 16, 8, 0, 0, 32, 0);
    // R3: smaller than one 8x4 tile, pixel walk
    rmode = 4; run_rect(3, 1, 3, 2, 1, 1, 40, 0);
    // 2x2 tiles, store
    rmode = 5; run_rect(1, 1, 6, 5, 4, 0, 200, 0);
    // R9: empty rectangle gives only done
    rmode = 0; run_rect(5, 5, 0, 4, 2, 1, 16, 0);
    // 4x2 tiles, right and bottom strips only
    rmode = 2; run_rect(4, 2, 9, 5, 3, 1, 128, 0);
    // R1: code 7 behaves as 16 bytes with 2x2 tiles
    rmode = 3; run_rect(3, 0, 5, 3, 7, 0, 300, 0);
    // tall thin rectangle, pixel walk across rows
    rmode = 0; run_rect(2, 3, 1, 12, 2, 1, 20, 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule